// File: doc/BRIEF.md
# Serial controller status and error flag unit

This block holds the mode state and the sticky error state of a serial controller. Two mode bits are kept: an enable bit, where 0 means configuration mode and 1 means operational mode, and a master-select bit. Six sticky error flags are kept next to them: mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. The logic that detects these errors sits outside the block. It reports each error as a one-cycle pulse. Five of the pulses pass only when their own detection-enable input is high. The mode-error pulse has no enable and always passes.

Software never writes a flag directly. It writes a command word that has one clear strobe and one set strobe for every flag. A single write can therefore raise some flags and drop others without first reading the status. The status word packs the flags together with an external busy indication. An error interrupt stays high for as long as any error flag is set. A read of the command word returns zero.

Top module: `ser_flag_ctrl`

## Requirements
- R1: After reset the status word is zero in every bit except bit 13, which shows `busyIn`. `errIrq` is low.
- R2: In a command write, bit 1 sets the enable flag and bit 0 clears it. Bit 3 sets the master-select flag and bit 2 clears it. The result is visible in the status word in the cycle after the write.
- R3: If one write carries both the set bit and the clear bit of the same flag, the flag ends up cleared.
- R4: The error command bits are mapped as follows. Bit 4 clears and bit 5 sets receive underflow. Bit 6 clears and bit 7 sets mode error. Bits 8, 9, 10 and 11 clear transmit overflow, receive overflow, abort and transmit underflow. Bits 12, 13, 14 and 15 set the same four flags.
- R5: The status word is laid out as follows. Bit 0 is enable and bit 1 is master select. Bit 7 is mode error. Bits 8 to 12 are transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Bit 13 is `busyIn`, passed through in the same cycle. All other bits read zero.
- R6: An event pulse sets its flag in the next cycle when its enable is high. `evtErr` and `errEnable` are indexed 0 to 4 as transmit overflow, receive overflow, abort, transmit underflow and receive underflow. An event whose enable is low never sets its flag. A `evtMode` pulse always sets the mode error flag.
- R7: If an enabled event and a clear command for the same flag arrive in the same cycle, the flag is left set.
- R8: Flags hold their value until a command changes them. A command word presented while `cmdWe` is low has no effect.
- R9: `errIrq` is high in exactly those cycles in which at least one of the six error flags is set. It falls in the cycle after the last set flag is cleared.
- R10: While `rdSelCmd` is high, `rdData` is zero. While it is low, `rdData` equals the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWe | input | 1 | Command word write strobe |
| cmdData | input | 16 | Command word of set and clear strobes |
| evtErr | input | 5 | Error event pulses that have an enable |
| evtMode | input | 1 | Mode error event pulse |
| errEnable | input | 5 | Per-error detection enables, indexed like `evtErr` |
| busyIn | input | 1 | Busy indication shown in the status word |
| rdSelCmd | input | 1 | Selects the command word, which reads as zero, on `rdData` |
| statusWord | output | 16 | Packed mode, error and busy status |
| errIrq | output | 1 | Error interrupt |
| rdData | output | 16 | Read data |

## Verification
Every flag is a single register stage. A command write or an event presented before a rising edge therefore appears in `statusWord` and `errIrq` right after that edge. `busyIn` and `rdSelCmd` act on their outputs combinationally within the same cycle. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, with the inputs of that step still applied, so each check falls in the cycle in which its result is due. A reference model in the bench is advanced at the same edge. Single-bit commands are swept exhaustively. A long pseudo-random run then mixes commands, events and enables.

// File: rtl/ser_flag_pkg.sv
package ser_flag_pkg;
  localparam int CMD_W     = 16;
  localparam int STAT_W    = 16;
  localparam int NUM_GATED = 5;              // errors that have a detection enable
  localparam int NUM_ERR   = NUM_GATED + 1;  // plus the mode error
  localparam int MODE_IDX  = NUM_ERR - 1;

  // Command word strobe positions
  localparam int EN_CLR_BIT = 0;
  localparam int EN_SET_BIT = 1;
  localparam int MS_CLR_BIT = 2;
  localparam int MS_SET_BIT = 3;
  // Per error index: 0 txOvf, 1 rxOvf, 2 abort, 3 txUnd, 4 rxUnd, 5 mode
  localparam int ERR_CLR_BIT [NUM_ERR] = '{8, 9, 10, 11, 4, 6};
  localparam int ERR_SET_BIT [NUM_ERR] = '{12, 13, 14, 15, 5, 7};

  // Status word positions
  localparam int EN_POS   = 0;
  localparam int MS_POS   = 1;
  localparam int BUSY_POS = 13;
  localparam int ERR_POS [NUM_ERR] = '{8, 9, 10, 11, 12, 7};

  typedef struct packed {
    logic               enClr;
    logic               enSet;
    logic               msClr;
    logic               msSet;
    logic [NUM_ERR-1:0] errClr;
    logic [NUM_ERR-1:0] errSet;
    logic [NUM_ERR-1:0] errHw;
  } flagCmd_t;
endpackage

// File: rtl/ser_flag_decode.sv
module ser_flag_decode
  import ser_flag_pkg::*;
(
  input  logic                 cmdWe,
  input  logic [CMD_W-1:0]     cmdData,
  input  logic [NUM_GATED-1:0] evtErr,
  input  logic                 evtMode,
  input  logic [NUM_GATED-1:0] errEnable,
  output flagCmd_t             strobes
);
  assign strobes.enClr = cmdWe & cmdData[EN_CLR_BIT];
  assign strobes.enSet = cmdWe & cmdData[EN_SET_BIT];
  assign strobes.msClr = cmdWe & cmdData[MS_CLR_BIT];
  assign strobes.msSet = cmdWe & cmdData[MS_SET_BIT];

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    assign strobes.errClr[i] = cmdWe & cmdData[ERR_CLR_BIT[i]];
    assign strobes.errSet[i] = cmdWe & cmdData[ERR_SET_BIT[i]];
    if (i < NUM_GATED) begin : g_gated
      assign strobes.errHw[i] = evtErr[i] & errEnable[i];
    end else begin : g_always
      assign strobes.errHw[i] = evtMode;
    end
  end
endmodule

// File: rtl/ser_flag_regs.sv
module ser_flag_regs
  import ser_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  flagCmd_t          strobes,
  input  logic              busyIn,
  input  logic              rdSelCmd,
  output logic [STAT_W-1:0] statusWord,
  output logic              errIrq,
  output logic [STAT_W-1:0] rdData
);
  logic               enQ;
  logic               msQ;
  logic [NUM_ERR-1:0] errQ;

  // Mode bits: clear has priority over set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= 1'b0;
      msQ <= 1'b0;
    end else begin
      if (strobes.enClr)      enQ <= 1'b0;
      else if (strobes.enSet) enQ <= 1'b1;
      if (strobes.msClr)      msQ <= 1'b0;
      else if (strobes.msSet) msQ <= 1'b1;
    end
  end

  // Error flags: hardware event > software clear > software set > hold
  for (genvar i = 0; i < NUM_ERR; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                  errQ[i] <= 1'b0;
      else if (strobes.errHw[i])  errQ[i] <= 1'b1;
      else if (strobes.errClr[i]) errQ[i] <= 1'b0;
      else if (strobes.errSet[i]) errQ[i] <= 1'b1;
    end
  end

  always_comb begin
    statusWord           = '0;
    statusWord[EN_POS]   = enQ;
    statusWord[MS_POS]   = msQ;
    statusWord[BUSY_POS] = busyIn;
    for (int i = 0; i < NUM_ERR; i++) statusWord[ERR_POS[i]] = errQ[i];
  end

  assign errIrq = |errQ;
  assign rdData = rdSelCmd ? '0 : statusWord;
endmodule

// File: rtl/ser_flag_ctrl.sv
module ser_flag_ctrl
  import ser_flag_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdWe,
  input  logic [CMD_W-1:0]     cmdData,
  input  logic [NUM_GATED-1:0] evtErr,
  input  logic                 evtMode,
  input  logic [NUM_GATED-1:0] errEnable,
  input  logic                 busyIn,
  input  logic                 rdSelCmd,
  output logic [STAT_W-1:0]    statusWord,
  output logic                 errIrq,
  output logic [STAT_W-1:0]    rdData
);
  flagCmd_t strobes;

  ser_flag_decode u_decode (
    .cmdWe     (cmdWe),
    .cmdData   (cmdData),
    .evtErr    (evtErr),
    .evtMode   (evtMode),
    .errEnable (errEnable),
    .strobes   (strobes)
  );

  ser_flag_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busyIn     (busyIn),
    .rdSelCmd   (rdSelCmd),
    .statusWord (statusWord),
    .errIrq     (errIrq),
    .rdData     (rdData)
  );
endmodule

// File: rtl/ser_flag_chk.sv
module ser_flag_chk
  import ser_flag_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdWe,
  input logic [CMD_W-1:0]     cmdData,
  input logic [NUM_GATED-1:0] evtErr,
  input logic                 evtMode,
  input logic [NUM_GATED-1:0] errEnable,
  input logic                 rdSelCmd,
  input logic [STAT_W-1:0]    statusWord,
  input logic                 errIrq,
  input logic [STAT_W-1:0]    rdData
);
  a_r2_enable_set: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && cmdData[1] && !cmdData[0]) |=> statusWord[0]);

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWe && cmdData[0] && cmdData[1]) |=> !statusWord[0]);

  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (evtErr[0] && errEnable[0]) |=> statusWord[8]);

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[8]) |->
      $past((evtErr[0] && errEnable[0]) || (cmdWe && cmdData[12] && !cmdData[8])));

  a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (evtMode && cmdWe && cmdData[6]) |=> statusWord[7]);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWe && evtErr == '0 && !evtMode) |=> $stable(statusWord[12:0]));

  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errIrq && !cmdWe) |=> errIrq);

  a_r10_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdSelCmd |-> (rdData == '0));
endmodule

bind ser_flag_ctrl ser_flag_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdWe      (cmdWe),
  .cmdData    (cmdData),
  .evtErr     (evtErr),
  .evtMode    (evtMode),
  .errEnable  (errEnable),
  .rdSelCmd   (rdSelCmd),
  .statusWord (statusWord),
  .errIrq     (errIrq),
  .rdData     (rdData)
);

// File: tb/sim_ser_flag_ctrl.sv
`timescale 1ns/1ps
module sim_ser_flag_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWe = 1'b0;
  logic [15:0] cmdData = '0;
  logic [4:0]  evtErr = '0;
  logic        evtMode = 1'b0;
  logic [4:0]  errEnable = '0;
  logic        busyIn = 1'b0;
  logic        rdSelCmd = 1'b0;
  logic [15:0] statusWord;
  logic        errIrq;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;

  // Reference state; error index 0 txOvf,1 rxOvf,2 abort,3 txUnd,4 rxUnd,5 mode
  logic       mEn = 1'b0;
  logic       mMs = 1'b0;
  logic [5:0] mErr = '0;

  always #2 clk = ~clk;

  ser_flag_ctrl u0 (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdData(cmdData),
    .evtErr(evtErr), .evtMode(evtMode), .errEnable(errEnable),
    .busyIn(busyIn), .rdSelCmd(rdSelCmd), .statusWord(statusWord),
    .errIrq(errIrq), .rdData(rdData)
  );

  function automatic logic [15:0] expStatus(input logic b);
    return {2'b00, b, mErr[4], mErr[3], mErr[2], mErr[1], mErr[0], mErr[5],
            5'b00000, mMs, mEn};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic we, input logic [15:0] cmd,
                      input logic [4:0] ev, input logic evm, input logic [4:0] en,
                      input logic busy);
    logic [5:0] clr, set, hw;
    @(negedge clk);
    cmdWe = we; cmdData = cmd; evtErr = ev; evtMode = evm;
    errEnable = en; busyIn = busy;
    clr = we ? {cmd[6], cmd[4], cmd[11], cmd[10], cmd[9], cmd[8]} : 6'b0;
    set = we ? {cmd[7], cmd[5], cmd[15], cmd[14], cmd[13], cmd[12]} : 6'b0;
    hw  = {evm, ev & en};
    @(posedge clk);
    if (we && cmd[0]) mEn = 1'b0; else if (we && cmd[1]) mEn = 1'b1;
    if (we && cmd[2]) mMs = 1'b0; else if (we && cmd[3]) mMs = 1'b1;
    mErr = hw | (~clr & (set | mErr));
    #1;
    check(tag, statusWord, expStatus(busy));
    check("R9 irq", {15'b0, errIrq}, {15'b0, |mErr});
    check("R10 read", rdData, rdSelCmd ? 16'h0 : expStatus(busy));
  endtask

  task automatic wr(input string tag, input logic [15:0] cmd);
    step(tag, 1'b1, cmd, 5'b0, 1'b0, 5'b0, 1'b0);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1 reset status", statusWord, 16'h0000);
    check("R1 reset irq", {15'b0, errIrq}, 16'h0000);

    // R2: mode bits
    wr("R2 set enable", 16'h0002);
    check("R2 enable bit", statusWord, 16'h0001);
    wr("R2 set master", 16'h0008);
    check("R2 master bit", statusWord, 16'h0003);
    wr("R2 clear enable", 16'h0001);
    wr("R2 clear master", 16'h0004);
    check("R2 both cleared", statusWord, 16'h0000);

    // R4: exhaustive single-bit command sweep, each followed by its inverse pair
    for (int b = 0; b < 16; b++) begin
      wr("R4 single bit", 16'h1 << b);
      wr("R4 clear all", 16'h0F55);
    end
    wr("R4 set all errors", 16'hF0A0);
    check("R4 all error flags", statusWord, 16'h1F80);
    wr("R4 clear rx underflow only", 16'h0010);
    check("R4 rx underflow cleared", statusWord, 16'h0F80);

    // R3: set and clear together clear
    wr("R3 set everything", 16'hF0AA);
    check("R3 all set", statusWord, 16'h1F83);
    wr("R3 set+clear all", 16'hFFFF);
    check("R3 clear wins", statusWord, 16'h0000);
    check("R9 irq low after clear", {15'b0, errIrq}, 16'h0000);

    // R6: disabled events never flag, enabled ones do, mode always
    step("R6 disabled events", 1'b0, 16'h0, 5'h1F, 1'b0, 5'h00, 1'b0);
    check("R6 nothing flagged", statusWord, 16'h0000);
    for (int i = 0; i < 5; i++) begin
      step("R6 enabled event", 1'b0, 16'h0, 5'h1 << i, 1'b0, 5'h1F, 1'b0);
      check("R6 single flag", statusWord, 16'h0100 << i);
      wr("R6 clear", 16'h0F50);
    end
    step("R6 mode event", 1'b0, 16'h0, 5'h0, 1'b1, 5'h0, 1'b0);
    check("R6 mode flag", statusWord, 16'h0080);
    check("R9 irq on mode", {15'b0, errIrq}, 16'h0001);

    // R7: event versus clear in the same cycle
    step("R7 event beats clear", 1'b1, 16'h0F50, 5'h04, 1'b1, 5'h04, 1'b0);
    check("R7 flags kept", statusWord, 16'h0480);

    // R8: command ignored without write strobe; flags hold
    step("R8 no strobe", 1'b0, 16'hFFFF, 5'h0, 1'b0, 5'h1F, 1'b0);
    step("R8 hold", 1'b0, 16'h0000, 5'h0, 1'b0, 5'h0, 1'b0);
    check("R8 unchanged", statusWord, 16'h0480);

    // R5: busy passthrough
    step("R5 busy high", 1'b0, 16'h0, 5'h0, 1'b0, 5'h0, 1'b1);
    check("R5 busy bit", statusWord, 16'h2480);

    // R10: command read returns zero
    @(negedge clk); rdSelCmd = 1'b1; #1;
    check("R10 cmd read zero", rdData, 16'h0000);
    @(negedge clk); rdSelCmd = 1'b0; #1;
    check("R10 status read", rdData, expStatus(busyIn));

    // Pseudo-random mix
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a, c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c = lfsr;
      step("R8 random mix", a[0] & a[3], a & c, c[4:0] & a[9:5], c[9] & c[2],
           c[14:10], a[15]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule